// File: doc/BRIEF.md
# Quad-Channel PCM Serial Port

This block is the digital serial side of a four-channel voice codec. Everything runs from one master bit clock. Transmit data leaves on one shared output pin with its own output enable. Receive data arrives on one shared input pin. Each channel exchanges one 8-bit sample per 8 kHz frame. Parallel transmit samples come in on a packed word, and received samples go out on a packed word with a one-cycle valid pulse per channel.

The `wide_mode` input selects the framing. With it low (narrow mode), each channel has its own transmit and receive frame strobe. Each strobe opens an 8-bit slot on its rising edge, whether the strobe is short or long. With it high (wide mode), only the channel-0 strobes count. Each one opens a 32-bit burst that carries channels 0, 1, 2 and 3 back to back. On the last bit of every burst the block pulses a cascade strobe in each direction. The next device on the bus uses that pulse as its own channel-0 strobe, so up to 32 devices can share one bus. Per-channel power-down inputs keep the transmit pin undriven during that channel's slot.

Top module: `pcm_quad_port`

## Requirements
- R1: After reset, `sdo_oe`, `rx_valid`, `tx_casc` and `rx_casc` are all low.
- R2: In narrow mode, a rising edge of `tx_sync[i]` seen at a clock edge E0 starts a transmit slot. In the cycle after E0 and the seven cycles after that, `sdo` carries `tx_data[8i+7:8i]`, MSB first, with `sdo_oe` high.
- R3: In narrow mode, a rising edge of `rx_sync[i]` at edge E0 opens a receive slot. `sdi` is sampled on the falling edge inside each of the eight cycles after E0, MSB first. The byte appears on `rx_data[8i+7:8i]` with `rx_valid[i]` high for one cycle, right after the eighth rising edge following E0.
- R4: A frame strobe held high for several cycles (long format) opens exactly one slot, timed from its rising edge, the same as a one-cycle strobe.
- R5: `sdi` values outside a receive slot are ignored: `rx_data` keeps its value and `rx_valid` stays low.
- R6: In wide mode, a rising edge of `tx_sync[0]` starts a 32-bit transmit burst. The burst carries channels 0, 1, 2, 3 in that order, each byte MSB first, over 32 consecutive cycles.
- R7: In wide mode, a rising edge of `rx_sync[0]` starts a 32-bit receive burst. Channel k's byte is reported with its `rx_valid[k]` pulse after the 8(k+1)-th rising edge from the start.
- R8: In wide mode, `tx_sync[3:1]` and `rx_sync[3:1]` have no effect.
- R9: In wide mode, `tx_casc` and `rx_casc` are high for exactly the one cycle that carries bit 31 of their burst. In narrow mode both stay low.
- R10: While `pdn[i]` is high, `sdo_oe` stays low during channel i's transmit slot. Other channels still transmit.
- R11: `sdo_oe` is low in every cycle outside an active transmit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock; transmit changes on rising edge, receive samples on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 0: per-channel 8-bit slots; 1: one 32-bit burst for all channels |
| tx_sync | input | 4 | Transmit frame strobes, one per channel |
| rx_sync | input | 4 | Receive frame strobes, one per channel |
| pdn | input | 4 | Per-channel power-down; high keeps the transmit pin undriven in that slot |
| tx_data | input | 32 | Transmit samples, channel i in bits 8i+7..8i |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rx_data | output | 32 | Last received sample per channel, channel i in bits 8i+7..8i |
| rx_valid | output | 4 | One-cycle pulse when a channel's receive byte is complete |
| tx_casc | output | 1 | Transmit cascade strobe on the final burst bit (wide mode) |
| rx_casc | output | 1 | Receive cascade strobe on the final burst bit (wide mode) |

## Verification
The hardest situation to reach is a wide-mode burst where the channel strobes 1 to 3 toggle in the middle of the burst while a channel is powered down. That single run shows that the stray strobes open no slot and that the powered-down gap does not shift the later channels. The bench drives whole bursts cycle by cycle, pulsing `tx_sync[2]` and `rx_sync[3]` partway through, with `pdn[1]` set. The scoreboard flags any enabled bit nobody expected and any bit or byte that comes out of order. It also checks the cascade strobes on every burst cycle.

// File: rtl/pcmq_pkg.sv
package pcmq_pkg;
    localparam int unsigned PCMQ_CHANNELS  = 4;
    localparam int unsigned PCMQ_SLOT_BITS = 8;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } pcmq_mode_e;
endpackage

// File: rtl/pcmq_frame_ctl.sv
module pcmq_frame_ctl #(
    parameter int unsigned CHANNELS  = 4,
    parameter int unsigned SLOT_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_i,
    input  logic [CHANNELS-1:0] sync_i,
    output logic [CHANNELS-1:0] start_o,
    output logic                casc_o
);
    localparam int unsigned FRAME_BITS = CHANNELS * SLOT_BITS;
    localparam int unsigned CW         = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST     = CW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CHANNELS-1:0] sync;
        logic                run;
        logic [CW-1:0]       cnt;
        logic                casc;
    } frame_t;

    frame_t              s_d, s_q;
    logic [CHANNELS-1:0] rise;

    always_comb begin
        s_d      = s_q;
        s_d.sync = sync_i;
        s_d.casc = 1'b0;
        rise     = sync_i & ~s_q.sync;
        start_o  = '0;
        if (wide_i) begin
            start_o[0] = rise[0];
            for (int k = 1; k < CHANNELS; k++) begin
                if (s_q.run && !rise[0] && s_q.cnt == CW'(k * SLOT_BITS)) begin
                    start_o[k] = 1'b1;
                end
            end
            if (rise[0]) begin
                s_d.run = 1'b1;
                s_d.cnt = CW'(1);
            end else if (s_q.run) begin
                if (s_q.cnt == LAST) begin
                    s_d.run  = 1'b0;
                    s_d.cnt  = '0;
                    s_d.casc = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
        end else begin
            start_o = rise;
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign casc_o = s_q.casc;
endmodule

// File: rtl/pcmq_tx_lane.sv
module pcmq_tx_lane #(
    parameter int unsigned SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [SLOT_BITS-1:0] sample_i,
    output logic                 bit_o,
    output logic                 active_o
);
    localparam int unsigned CW   = $clog2(SLOT_BITS);
    localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

    typedef struct packed {
        logic                 active;
        logic [CW-1:0]        cnt;
        logic [SLOT_BITS-1:0] sh;
    } tx_lane_t;

    tx_lane_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (start_i) begin
            l_d.active = 1'b1;
            l_d.cnt    = '0;
            l_d.sh     = sample_i;
        end else if (l_q.active) begin
            l_d.sh  = {l_q.sh[SLOT_BITS-2:0], 1'b0};
            l_d.cnt = l_q.cnt + CW'(1);
            if (l_q.cnt == LAST) begin
                l_d.active = 1'b0;
                l_d.cnt    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign bit_o    = l_q.sh[SLOT_BITS-1];
    assign active_o = l_q.active;
endmodule

// File: rtl/pcmq_rx_lane.sv
module pcmq_rx_lane #(
    parameter int unsigned SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 bit_i,
    output logic [SLOT_BITS-1:0] data_o,
    output logic                 valid_o
);
    localparam int unsigned CW   = $clog2(SLOT_BITS);
    localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

    typedef struct packed {
        logic                 active;
        logic [CW-1:0]        cnt;
        logic [SLOT_BITS-1:0] sh;
        logic [SLOT_BITS-1:0] data;
        logic                 valid;
    } rx_lane_t;

    rx_lane_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.valid = 1'b0;
        if (start_i) begin
            l_d.active = 1'b1;
            l_d.cnt    = '0;
        end else if (l_q.active) begin
            l_d.sh  = {l_q.sh[SLOT_BITS-2:0], bit_i};
            l_d.cnt = l_q.cnt + CW'(1);
            if (l_q.cnt == LAST) begin
                l_d.active = 1'b0;
                l_d.cnt    = '0;
                l_d.data   = {l_q.sh[SLOT_BITS-2:0], bit_i};
                l_d.valid  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign data_o  = l_q.data;
    assign valid_o = l_q.valid;
endmodule

// File: rtl/pcm_quad_port.sv
module pcm_quad_port
    import pcmq_pkg::*;
#(
    parameter int unsigned CHANNELS  = PCMQ_CHANNELS,
    parameter int unsigned SLOT_BITS = PCMQ_SLOT_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wide_mode,
    input  logic [CHANNELS-1:0]           tx_sync,
    input  logic [CHANNELS-1:0]           rx_sync,
    input  logic [CHANNELS-1:0]           pdn,
    input  logic [CHANNELS*SLOT_BITS-1:0] tx_data,
    input  logic                          sdi,
    output logic                          sdo,
    output logic                          sdo_oe,
    output logic [CHANNELS*SLOT_BITS-1:0] rx_data,
    output logic [CHANNELS-1:0]           rx_valid,
    output logic                          tx_casc,
    output logic                          rx_casc
);
    pcmq_mode_e          mode;
    logic                wide;
    logic [CHANNELS-1:0] tx_start, rx_start;
    logic [CHANNELS-1:0] tx_bit, tx_act;
    logic                sdi_d, sdi_q;

    assign mode  = pcmq_mode_e'(wide_mode);
    assign wide  = (mode == MODE_WIDE);
    assign sdi_d = sdi;

    // receive data is captured on the falling edge, mid-bit
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdi_q <= 1'b0;
        end else begin
            sdi_q <= sdi_d;
        end
    end

    pcmq_frame_ctl #(.CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS)) u_tx_frame (
        .clk(clk), .rst_n(rst_n), .wide_i(wide), .sync_i(tx_sync),
        .start_o(tx_start), .casc_o(tx_casc)
    );

    pcmq_frame_ctl #(.CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS)) u_rx_frame (
        .clk(clk), .rst_n(rst_n), .wide_i(wide), .sync_i(rx_sync),
        .start_o(rx_start), .casc_o(rx_casc)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_lane
        pcmq_tx_lane #(.SLOT_BITS(SLOT_BITS)) u_tx (
            .clk(clk), .rst_n(rst_n), .start_i(tx_start[g]),
            .sample_i(tx_data[g*SLOT_BITS +: SLOT_BITS]),
            .bit_o(tx_bit[g]), .active_o(tx_act[g])
        );
        pcmq_rx_lane #(.SLOT_BITS(SLOT_BITS)) u_rx (
            .clk(clk), .rst_n(rst_n), .start_i(rx_start[g]), .bit_i(sdi_q),
            .data_o(rx_data[g*SLOT_BITS +: SLOT_BITS]), .valid_o(rx_valid[g])
        );
    end

    // lowest-numbered active lane owns the pin
    always_comb begin
        sdo    = 1'b0;
        sdo_oe = 1'b0;
        for (int i = CHANNELS - 1; i >= 0; i--) begin
            if (tx_act[i]) begin
                sdo    = tx_bit[i];
                sdo_oe = ~pdn[i];
            end
        end
    end
endmodule

// File: rtl/pcmq_port_checker.sv
module pcmq_port_checker #(
    parameter int unsigned CHANNELS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wide_mode,
    input logic [CHANNELS-1:0] pdn,
    input logic                sdo_oe,
    input logic [CHANNELS-1:0] rx_valid,
    input logic                tx_casc,
    input logic                rx_casc
);
    a_r9_tx_casc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_casc |=> !tx_casc);

    a_r9_rx_casc_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_casc |=> !rx_casc);

    a_r9_casc_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_casc || rx_casc) |-> $past(wide_mode));

    a_r9_casc_on_driven_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_casc && wide_mode && $past(wide_mode) && !pdn[CHANNELS-1]) |-> sdo_oe);

    a_r10_all_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&pdn) |-> !sdo_oe);

    for (genvar g = 0; g < CHANNELS; g++) begin : g_valid
        a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[g] |=> !rx_valid[g]);
    end
endmodule

bind pcm_quad_port pcmq_port_checker #(.CHANNELS(CHANNELS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .pdn(pdn),
    .sdo_oe(sdo_oe), .rx_valid(rx_valid), .tx_casc(tx_casc), .rx_casc(rx_casc)
);

// File: tb/pcm_quad_port_test.sv
module pcm_quad_port_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wide_mode;
    logic [3:0]  tx_sync, rx_sync, pdn;
    logic [31:0] tx_data;
    logic        sdi;
    logic        sdo, sdo_oe;
    logic [31:0] rx_data;
    logic [3:0]  rx_valid;
    logic        tx_casc, rx_casc;

    int n_chk = 0;
    int n_err = 0;
    logic       exp_tx[$];
    logic [9:0] exp_rx[$];
    logic       mon_bit;
    logic [9:0] mon_item;

    always #2 clk = ~clk;

    pcm_quad_port uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .tx_sync(tx_sync),
        .rx_sync(rx_sync), .pdn(pdn), .tx_data(tx_data), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_casc(tx_casc), .rx_casc(rx_casc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // monitor: compare outputs against the scoreboard queues
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            if (sdo_oe) begin
                if (exp_tx.size() == 0) begin
                    check(1'b0, "R11 sdo_oe outside slot", 1, 0);
                end else begin
                    mon_bit = exp_tx.pop_front();
                    check(sdo == mon_bit, "R2 R6 transmit bit", sdo, mon_bit);
                end
            end
            for (int c = 0; c < 4; c++) begin
                if (rx_valid[c]) begin
                    if (exp_rx.size() == 0) begin
                        check(1'b0, "R5 unexpected rx_valid", c, 0);
                    end else begin
                        mon_item = exp_rx.pop_front();
                        check({c[1:0], rx_data[c*8 +: 8]} == mon_item, "R3 R7 received byte",
                              {c[1:0], rx_data[c*8 +: 8]}, mon_item);
                    end
                end
            end
        end
    end

    task automatic send_narrow(input int ch, input logic [7:0] b, input int len);
        if (!pdn[ch]) for (int k = 7; k >= 0; k--) exp_tx.push_back(b[k]);
        tx_data[ch*8 +: 8] = b;
        tx_sync[ch] = 1'b1;
        for (int k = 0; k < len; k++) cyc();
        tx_sync[ch] = 1'b0;
        for (int k = 0; k < 10; k++) cyc();
        check(exp_tx.size() == 0, "R2 R4 slot fully sent", exp_tx.size(), 0);
        check(tx_casc == 1'b0, "R9 no cascade in narrow mode", tx_casc, 0);
    endtask

    task automatic recv_narrow(input int ch, input logic [7:0] b, input int len);
        exp_rx.push_back({ch[1:0], b});
        rx_sync[ch] = 1'b1;
        for (int k = 0; k < 8; k++) begin
            cyc();
            sdi = b[7-k];
            if (k + 1 >= len) rx_sync[ch] = 1'b0;
        end
        cyc();
        sdi = ~sdi;
        for (int k = 0; k < 4; k++) cyc();
        check(exp_rx.size() == 0, "R3 R4 byte received", exp_rx.size(), 0);
        check(rx_casc == 1'b0, "R9 no rx cascade in narrow mode", rx_casc, 0);
    endtask

    task automatic burst(input logic [31:0] txw, input logic [31:0] rxw);
        for (int k = 0; k < 32; k++) begin
            if (!pdn[k/8]) exp_tx.push_back(txw[(k/8)*8 + 7 - (k%8)]);
        end
        for (int c = 0; c < 4; c++) exp_rx.push_back({c[1:0], rxw[c*8 +: 8]});
        tx_data = txw;
        tx_sync[0] = 1'b1;
        rx_sync[0] = 1'b1;
        for (int k = 0; k < 32; k++) begin
            cyc();
            if (k == 0) begin
                tx_sync[0] = 1'b0;
                rx_sync[0] = 1'b0;
            end
            if (k == 5) begin
                tx_sync[2] = 1'b1;   // R8 stray strobes mid-burst
                rx_sync[3] = 1'b1;
            end
            if (k == 7) begin
                tx_sync[2] = 1'b0;
                rx_sync[3] = 1'b0;
            end
            sdi = rxw[(k/8)*8 + 7 - (k%8)];
            check(tx_casc == (k == 31), "R9 tx cascade timing", tx_casc, (k == 31));
            check(rx_casc == (k == 31), "R9 rx cascade timing", rx_casc, (k == 31));
        end
        cyc();
        check(tx_casc == 1'b0 && rx_casc == 1'b0, "R9 cascade ends", {tx_casc, rx_casc}, 0);
        sdi = 1'b1;
        for (int k = 0; k < 8; k++) cyc();
        check(exp_tx.size() == 0, "R6 R8 burst transmitted", exp_tx.size(), 0);
        check(exp_rx.size() == 0, "R7 R8 burst received", exp_rx.size(), 0);
    endtask

    initial begin
        #800000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wide_mode = 1'b0;
        tx_sync = '0;
        rx_sync = '0;
        pdn = '0;
        tx_data = '0;
        sdi = 1'b0;
        for (int k = 0; k < 3; k++) cyc();
        rst_n = 1'b1;
        cyc();
        check(sdo_oe == 1'b0, "R1 sdo_oe after reset", sdo_oe, 0);
        check(rx_valid == 4'h0, "R1 rx_valid after reset", rx_valid, 0);
        check(tx_casc == 1'b0 && rx_casc == 1'b0, "R1 cascade after reset", {tx_casc, rx_casc}, 0);

        send_narrow(0, 8'hA5, 1);                 // R2
        send_narrow(3, 8'h3C, 1);                 // R2
        send_narrow(1, 8'h96, 4);                 // R4 long strobe
        recv_narrow(0, 8'hC3, 1);                 // R3
        recv_narrow(2, 8'h5A, 1);                 // R3
        recv_narrow(3, 8'h81, 5);                 // R4 long strobe

        // R5: toggle sdi with no slot open
        for (int k = 0; k < 12; k++) begin
            sdi = k[0];
            cyc();
        end
        check(rx_data[7:0] == 8'hC3, "R5 ch0 byte untouched", rx_data[7:0], 8'hC3);
        check(rx_data[31:24] == 8'h81, "R5 ch3 byte untouched", rx_data[31:24], 8'h81);

        // R10: channel 2 powered down, channel 1 still sends
        pdn = 4'b0100;
        send_narrow(2, 8'hFF, 1);
        send_narrow(1, 8'h0F, 1);
        pdn = 4'b0000;

        wide_mode = 1'b1;
        for (int k = 0; k < 3; k++) cyc();
        burst(32'h12345678, 32'h9ABCDEF0);        // R6 R7 R8 R9
        pdn = 4'b0010;                            // R10 in wide mode
        burst(32'hDEADBEEF, 32'h0F1E2D3C);
        pdn = 4'b0000;
        check(sdo_oe == 1'b0, "R11 idle after bursts", sdo_oe, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule